// File: doc/BRIEF.md
# Waveform Timer Channel

A single timer channel that runs a counter and shapes two output waveforms, `wave_a` and `wave_b`, from where that counter stands relative to three compare registers (called RA, RB and RC here). The counter advances on edges of a chosen count source. That source is either the internal prescaled clock level or one of three external lines. It can be inverted and qualified by a gate line. Four counting profiles are available: two free-running ones over the full range and two bounded by RC. Each profile either wraps or bounces.

Each output pin has four event slots: its own compare, the RC compare, an external event and a software trigger. Each slot carries a set, clear, toggle or no-op action. Sticky event flags, an interrupt mask and an interrupt request let a host react to compare, overflow and external-event activity. Registers are loaded through one shared data bus with a write strobe per register.

Top module: `wave_timer`

## Requirements
- R1: While `rst` is high, and after it is released, the count is 0, both pins are low, `status` is all zero, the clock is off and `irq` is low.
- R2: A command write takes `wr_data` bit0 as clock on, bit1 as clock off and bit2 as software trigger. When bits 0 and 1 are both set, the clock turns off. `status` bit16 shows the clock state. While the clock is off, the counter does not advance.
- R3: The mode word holds the count source in bits [1:0] (0 is `tclk_in`, k=1..3 is `xline[k-1]`) and the invert bit in bit2. Without invert, the counter advances once on each rising edge of the source; with invert, once on each falling edge. A gate code in bits [4:3] of k>0 allows counting only while `xline[k-1]` is high.
- R4: Profile 0 (mode bits [13:12]) counts up and wraps from the maximum value to 0. Each wrap sets overflow flag bit0.
- R5: Profile 1 counts 0 up to the maximum value and back down to 0, then repeats. Turning at the maximum sets bit0.
- R6: Profile 2 counts 0 up to RC and restarts at 0 on the next count.
- R7: Profile 3 counts 0 up to RC and back down to 0, then repeats.
- R8: When a count step lands on RA, RB or RC, status bit2, bit3 or bit4 is set.
- R9: Action codes are 0 none, 1 set, 2 clear, 3 toggle. Pin A uses mode bits [21:14] and pin B uses bits [29:22]. Within each byte, [1:0] is the pin's own compare, [3:2] the RC compare, [5:4] the external event and [7:6] the software trigger. When events coincide, the software trigger beats the external event, which beats RC, which beats the pin's own compare. An event whose code is 0 is passed over.
- R10: Mode bit5 freezes the counter when it lands on RC. Mode bit6 turns the clock off when it lands on RC.
- R11: A software trigger returns the counter to 0 counting upward and releases a freeze. So does an external event when mode bit11 is set.
- R12: The external event source is in mode bits [10:9] (0 is `pin_b_in`, k is `xline[k-1]`). The edge is in bits [8:7] (0 none, 1 rising, 2 falling, 3 both). A detected event sets status bit7.
- R13: A `rd_status` pulse clears status bits 0-7. Status bit17 follows `wave_a` and bit18 follows `wave_b`.
- R14: `wr_ien` sets mask bits and `wr_idis` clears them, taken from `wr_data[7:0]`. If both strobes name a bit, that bit ends up cleared. `irq` is the OR of the flags whose mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_in | input | 1 | Level of the selected internal prescaled clock |
| xline | input | 3 | External clock/gate/event lines |
| pin_b_in | input | 1 | Pin B level used as an event source |
| wr_cmd | input | 1 | Command write strobe |
| wr_mode | input | 1 | Mode write strobe |
| wr_ra | input | 1 | RA write strobe |
| wr_rb | input | 1 | RB write strobe |
| wr_rc | input | 1 | RC write strobe |
| wr_ien | input | 1 | Interrupt mask set strobe |
| wr_idis | input | 1 | Interrupt mask clear strobe |
| wr_data | input | 30 | Write data for all registers |
| rd_status | input | 1 | Status read strobe, clears event flags |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| count | output | CNT_W | Counter value |
| status | output | 32 | Flags, clock state and pin mirrors |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks the counter through each profile far enough to hit both turning points. A design that wraps or bounces one step early or late, or that forgets its direction after a trigger, drifts away from the closed-form position. Coincident events are staged deliberately: RA equal to RC, and a software trigger on the same edge as an external edge. A wrong priority then leaves the pin at the opposite level. Each pin is also stepped through every action code, so a swapped set/clear decode shows up. The freeze and clock-off on RC, inverted and gated counting, edge-selected events and the disable-over-enable rules are each probed where a wrong design would keep counting or stop counting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        PR_WRAP     = 2'd0,
        PR_BOUNCE   = 2'd1,
        PR_WRAP_RC  = 2'd2,
        PR_BOUNCE_RC = 2'd3
    } profile_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_e;

    // Per-pin action set; own compare sits in the low bits.
    typedef struct packed {
        act_e sw;
        act_e ev;
        act_e rc;
        act_e cmp;
    } pin_cfg_t;

    typedef struct packed {
        pin_cfg_t   pin_b;
        pin_cfg_t   pin_a;
        profile_e   profile;
        logic       ev_trig;
        logic [1:0] ev_src;
        edge_e      ev_edge;
        logic       dis_on_rc;
        logic       stop_on_rc;
        logic [1:0] gate_sel;
        logic       clk_inv;
        logic [1:0] clk_src;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam int CMD_EN  = 0;
    localparam int CMD_DIS = 1;
    localparam int CMD_SW  = 2;

    localparam int ST_OVF = 0;
    localparam int ST_CPA = 2;
    localparam int ST_CPB = 3;
    localparam int ST_CPC = 4;
    localparam int ST_EVT = 7;
    localparam int ST_CLK = 16;
    localparam int ST_PA  = 17;
    localparam int ST_PB  = 18;

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_sources.sv
module tmr_sources
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tclk_in,
    input  logic [2:0] xline,
    input  logic       pin_b_in,
    input  logic [1:0] clk_src,
    input  logic       clk_inv,
    input  logic [1:0] gate_sel,
    input  logic [1:0] ev_src,
    input  edge_e      ev_edge,
    output logic       tick,
    output logic       ev_hit
);
    logic [3:0] ck_now, ck_old, ev_now, ev_old, gate_vec;
    logic       c_n, c_o, e_n, e_o;

    assign ck_now   = {xline, tclk_in};
    assign ev_now   = {xline, pin_b_in};
    assign gate_vec = {xline, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_old <= '0;
            ev_old <= '0;
        end else begin
            ck_old <= ck_now;
            ev_old <= ev_now;
        end
    end

    assign c_n = ck_now[clk_src];
    assign c_o = ck_old[clk_src];
    assign e_n = ev_now[ev_src];
    assign e_o = ev_old[ev_src];

    assign tick = gate_vec[gate_sel] & (clk_inv ? (c_o & ~c_n) : (~c_o & c_n));

    always_comb begin
        case (ev_edge)
            EDGE_RISE: ev_hit = ~e_o & e_n;
            EDGE_FALL: ev_hit = e_o & ~e_n;
            EDGE_BOTH: ev_hit = e_o ^ e_n;
            default:   ev_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             trig,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  profile_e         profile,
    input  logic             stop_on_rc,
    input  logic             dis_on_rc,
    input  logic [CNT_W-1:0] ra,
    input  logic [CNT_W-1:0] rb,
    input  logic [CNT_W-1:0] rc,
    output logic [CNT_W-1:0] cnt,
    output logic             clk_on,
    output logic             adv,
    output logic             hit_a,
    output logic             hit_b,
    output logic             hit_c,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0]       pbits;
    logic             bounce, rc_top;
    logic             up_q, stop_q, nxt_up;
    logic [CNT_W-1:0] nxt;

    assign pbits  = profile;
    assign bounce = pbits[0];
    assign rc_top = pbits[1];
    assign adv    = tick & clk_on & ~stop_q & ~trig;

    always_comb begin
        nxt    = cnt + 1'b1;
        nxt_up = up_q;
        if (up_q) begin
            if (rc_top && cnt == rc) begin
                if (bounce) begin
                    nxt    = (cnt == '0) ? '0 : cnt - 1'b1;
                    nxt_up = 1'b0;
                end else begin
                    nxt = '0;
                end
            end else if (bounce && cnt == CNT_MAX) begin
                nxt    = cnt - 1'b1;
                nxt_up = 1'b0;
            end
        end else if (cnt == '0) begin
            nxt    = (rc_top && rc == '0) ? '0 : CNT_W'(1);
            nxt_up = 1'b1;
        end else begin
            nxt = cnt - 1'b1;
        end
    end

    assign ovf   = adv & up_q & (cnt == CNT_MAX);
    assign hit_a = adv & (nxt == ra);
    assign hit_b = adv & (nxt == rb);
    assign hit_c = adv & (nxt == rc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            up_q   <= 1'b1;
            stop_q <= 1'b0;
            clk_on <= 1'b0;
        end else begin
            if (cmd_dis || (hit_c && dis_on_rc)) clk_on <= 1'b0;
            else if (cmd_en)                     clk_on <= 1'b1;
            if (trig) begin
                cnt    <= '0;
                up_q   <= 1'b1;
                stop_q <= 1'b0;
            end else if (adv) begin
                cnt  <= nxt;
                up_q <= nxt_up;
                if (hit_c && stop_on_rc) stop_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     ev_sw,
    input  logic     ev_ext,
    input  logic     ev_rc,
    input  logic     ev_cmp,
    output logic     pin
);
    act_e act;

    // Later assignments override earlier ones: ascending priority.
    always_comb begin
        act = ACT_NONE;
        if (ev_cmp && cfg.cmp != ACT_NONE) act = cfg.cmp;
        if (ev_rc  && cfg.rc  != ACT_NONE) act = cfg.rc;
        if (ev_ext && cfg.ev  != ACT_NONE) act = cfg.ev;
        if (ev_sw  && cfg.sw  != ACT_NONE) act = cfg.sw;
    end

    always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= apply_act(act, pin);
    end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] new_ev,
    input  logic       rd_clr,
    input  logic       ien,
    input  logic       idis,
    input  logic [7:0] wdata,
    output logic [7:0] flags,
    output logic       irq
);
    logic [7:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            mask_q <= '0;
        end else begin
            flags  <= (rd_clr ? 8'h00 : flags) | new_ev;
            mask_q <= (mask_q | (ien ? wdata : 8'h00)) & ~(idis ? wdata : 8'h00);
        end
    end

    assign irq = |(flags & mask_q);
endmodule

// File: rtl/wave_timer.sv
module wave_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tclk_in,
    input  logic [2:0]        xline,
    input  logic              pin_b_in,
    input  logic              wr_cmd,
    input  logic              wr_mode,
    input  logic              wr_ra,
    input  logic              wr_rb,
    input  logic              wr_rc,
    input  logic              wr_ien,
    input  logic              wr_idis,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              rd_status,
    output logic              wave_a,
    output logic              wave_b,
    output logic [CNT_W-1:0]  count,
    output logic [31:0]       status,
    output logic              irq
);
    mode_t            mode_q;
    logic [CNT_W-1:0] ra_q, rb_q, rc_q;
    logic             tick, ev_hit, sw_trig, trig;
    logic             clk_on, cnt_adv, hit_a, hit_b, hit_c, ovf;
    logic [7:0]       flags;
    pin_cfg_t         pcfg [2];
    logic [1:0]       own_hit, pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            rc_q   <= '0;
        end else begin
            if (wr_mode) mode_q <= mode_t'(wr_data);
            if (wr_ra)   ra_q   <= wr_data[CNT_W-1:0];
            if (wr_rb)   rb_q   <= wr_data[CNT_W-1:0];
            if (wr_rc)   rc_q   <= wr_data[CNT_W-1:0];
        end
    end

    assign sw_trig = wr_cmd & wr_data[CMD_SW];
    assign trig    = sw_trig | (ev_hit & mode_q.ev_trig);

    tmr_sources u_src (
        .clk(clk), .rst(rst), .tclk_in(tclk_in), .xline(xline), .pin_b_in(pin_b_in),
        .clk_src(mode_q.clk_src), .clk_inv(mode_q.clk_inv), .gate_sel(mode_q.gate_sel),
        .ev_src(mode_q.ev_src), .ev_edge(mode_q.ev_edge), .tick(tick), .ev_hit(ev_hit)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .trig(trig),
        .cmd_en(wr_cmd & wr_data[CMD_EN]), .cmd_dis(wr_cmd & wr_data[CMD_DIS]),
        .profile(mode_q.profile), .stop_on_rc(mode_q.stop_on_rc), .dis_on_rc(mode_q.dis_on_rc),
        .ra(ra_q), .rb(rb_q), .rc(rc_q), .cnt(count), .clk_on(clk_on), .adv(cnt_adv),
        .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c), .ovf(ovf)
    );

    assign pcfg[0] = mode_q.pin_a;
    assign pcfg[1] = mode_q.pin_b;
    assign own_hit = {hit_b, hit_a};

    for (genvar g = 0; g < 2; g++) begin : g_pin
        tmr_pin u_pin (
            .clk(clk), .rst(rst), .cfg(pcfg[g]), .ev_sw(sw_trig), .ev_ext(ev_hit),
            .ev_rc(hit_c), .ev_cmp(own_hit[g]), .pin(pin_q[g])
        );
    end

    tmr_flags u_flg (
        .clk(clk), .rst(rst),
        .new_ev({ev_hit, 2'b00, hit_c, hit_b, hit_a, 1'b0, ovf}),
        .rd_clr(rd_status), .ien(wr_ien), .idis(wr_idis), .wdata(wr_data[7:0]),
        .flags(flags), .irq(irq)
    );

    assign wave_a = pin_q[0];
    assign wave_b = pin_q[1];
    assign status = {13'b0, pin_q[1], pin_q[0], clk_on, 8'b0, flags};
endmodule

// File: rtl/wave_timer_chk.sv
module wave_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_cmd,
    input logic [2:0]       cmd_bits,
    input logic [CNT_W-1:0] count,
    input logic [31:0]      status,
    input logic             irq,
    input logic             adv,
    input logic [1:0]       prof
);
    AST_DIS_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && cmd_bits[1]) |=> !status[16]); // R2

    AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && cmd_bits[2]) |=> (count == '0)); // R11

    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
        !adv |=> (count == $past(count) || count == '0)); // R3

    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && prof == 2'd0) |=> (count == CNT_W'($past(count) + 1'b1))); // R4

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (status[7:0] == 8'h00) |-> !irq); // R14
endmodule

bind wave_timer wave_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .cmd_bits(wr_data[2:0]), .count(count),
    .status(status), .irq(irq), .adv(cnt_adv), .prof(mode_q.profile)
);

// File: tb/test_wave_timer.sv
module test_wave_timer;
    import tmr_pkg::*;

    localparam int CLK_P = 10;
    localparam int CW    = 4;
    localparam int RCV   = 9;

    logic clk = 1'b0, rst = 1'b1, tclk_in = 1'b0, pin_b_in = 1'b0, rd_status = 1'b0;
    logic [2:0] xline = 3'b000;
    logic wr_cmd = 0, wr_mode = 0, wr_ra = 0, wr_rb = 0, wr_rc = 0, wr_ien = 0, wr_idis = 0;
    logic [MODE_W-1:0] wr_data = '0;
    logic wave_a, wave_b, irq;
    logic [CW-1:0] count;
    logic [31:0] status;

    int n_chk = 0, n_fail = 0;
    mode_t m;

    always #(CLK_P/2) clk = ~clk;

    wave_timer #(.CNT_W(CW)) i_wave_timer (
        .clk(clk), .rst(rst), .tclk_in(tclk_in), .xline(xline), .pin_b_in(pin_b_in),
        .wr_cmd(wr_cmd), .wr_mode(wr_mode), .wr_ra(wr_ra), .wr_rb(wr_rb), .wr_rc(wr_rc),
        .wr_ien(wr_ien), .wr_idis(wr_idis), .wr_data(wr_data), .rd_status(rd_status),
        .wave_a(wave_a), .wave_b(wave_b), .count(count), .status(status), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // strobe select: 0 cmd, 1 mode, 2 ra, 3 rb, 4 rc, 5 ien, 6 idis
    task automatic wreg(input int sel, input logic [MODE_W-1:0] d);
        wr_data = d;
        case (sel)
            0: wr_cmd = 1;  1: wr_mode = 1; 2: wr_ra = 1; 3: wr_rb = 1;
            4: wr_rc = 1;   5: wr_ien = 1;  default: wr_idis = 1;
        endcase
        step();
        {wr_cmd, wr_mode, wr_ra, wr_rb, wr_rc, wr_ien, wr_idis} = '0;
        wr_data = '0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tclk_in = 1; step();
            tclk_in = 0; step();
        end
    endtask

    task automatic rd_clear();
        rd_status = 1; step(); rd_status = 0;
    endtask

    task automatic swtrig();
        wreg(0, 30'd4);
    endtask

    function automatic int exp_cnt(input int prof, input int n);
        int mx = (1 << CW) - 1;
        int k;
        case (prof)
            0: return n % (mx + 1);
            1: begin k = n % (2 * mx); return (k <= mx) ? k : 2 * mx - k; end
            2: return n % (RCV + 1);
            default: begin k = n % (2 * RCV); return (k <= RCV) ? k : 2 * RCV - k; end
        endcase
    endfunction

    function automatic logic act_res(input int code, input logic p);
        case (code)
            1: return 1'b1;
            2: return 1'b0;
            3: return ~p;
            default: return p;
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic pa, pb;
        repeat (3) step();
        chk("R1 count", count, 0);
        chk("R1 status", status, 0);
        chk("R1 pins", {wave_b, wave_a}, 0);
        chk("R1 irq", irq, 0);
        rst = 0;
        step();
        chk("R1 after release", status, 0);

        wreg(2, 30'd3); wreg(3, 30'd5); wreg(4, RCV);
        tick(2);
        chk("R2 no count while off", count, 0);
        wreg(0, 30'd1);
        chk("R2 clock on", status[ST_CLK], 1);

        // Profile sweep R4 R5 R6 R7
        for (int p = 0; p < 4; p++) begin
            m = '0; m.profile = profile_e'(p);
            wreg(1, m); swtrig(); rd_clear();
            for (int n = 1; n <= 40; n++) begin
                tick(1);
                chk($sformatf("R%0d profile %0d step %0d", 4 + p, p, n), count, exp_cnt(p, n));
            end
            chk($sformatf("R%0d overflow flag", 4 + p), status[ST_OVF], (p < 2) ? 1 : 0);
        end

        // R8 compare flags
        m = '0; wreg(1, m); swtrig(); rd_clear();
        tick(3);
        chk("R8 RA flag", status[ST_CPA], 1);
        chk("R8 RB early", status[ST_CPB], 0);
        tick(2);
        chk("R8 RB flag", status[ST_CPB], 1);
        chk("R8 RC early", status[ST_CPC], 0);
        tick(4);
        chk("R8 RC flag", status[ST_CPC], 1);

        // R9 software-trigger action sweep on both pins
        pa = wave_a; pb = wave_b;
        for (int rep = 0; rep < 2; rep++) begin
            for (int c = 0; c < 4; c++) begin
                m = '0; m.pin_a.sw = act_e'(c); m.pin_b.sw = act_e'(3 - c);
                wreg(1, m); swtrig();
                pa = act_res(c, pa); pb = act_res(3 - c, pb);
                chk("R9 sw action A", wave_a, pa);
                chk("R9 sw action B", wave_b, pb);
                chk("R13 mirror A", status[ST_PA], pa);
                chk("R13 mirror B", status[ST_PB], pb);
            end
        end

        // R9 own compare actions
        m = '0; m.pin_a.sw = ACT_CLR; m.pin_b.sw = ACT_CLR;
        wreg(1, m); swtrig();
        m = '0; m.pin_a.cmp = ACT_TGL; m.pin_b.cmp = ACT_SET;
        wreg(1, m); swtrig();
        tick(3);
        chk("R9 RA toggles A", wave_a, 1);
        chk("R9 B before RB", wave_b, 0);
        tick(2);
        chk("R9 RB sets B", wave_b, 1);

        // R9 priority: RC beats own compare
        m = '0; m.pin_a.sw = ACT_SET; wreg(1, m); swtrig();
        wreg(2, RCV);
        m = '0; m.pin_a.cmp = ACT_SET; m.pin_a.rc = ACT_CLR; wreg(1, m); swtrig();
        tick(RCV);
        chk("R9 RC over RA", wave_a, 0);
        wreg(2, 30'd3);

        // R9 priority: software trigger beats external event
        m = '0; m.pin_a.sw = ACT_SET; m.pin_a.ev = ACT_CLR; m.ev_edge = EDGE_RISE;
        wreg(1, m); rd_clear();
        pin_b_in = 1; wreg(0, 30'd4);
        chk("R9 sw over event", wave_a, 1);
        chk("R12 event flag", status[ST_EVT], 1);
        // R9 an event with code none is passed over
        m = '0; m.pin_a.ev = ACT_TGL; m.ev_edge = EDGE_BOTH;
        wreg(1, m);
        pin_b_in = 0; wreg(0, 30'd4);
        chk("R9 none passed over", wave_a, 0);

        // R10 stop on RC
        m = '0; m.stop_on_rc = 1; wreg(1, m); swtrig();
        tick(12);
        chk("R10 frozen at RC", count, RCV);
        chk("R10 clock still on", status[ST_CLK], 1);
        swtrig();
        tick(1);
        chk("R11 trigger releases freeze", count, 1);
        // R10 disable on RC
        m = '0; m.dis_on_rc = 1; wreg(1, m); swtrig();
        tick(12);
        chk("R10 held after disable", count, RCV);
        chk("R10 clock off", status[ST_CLK], 0);
        m = '0; wreg(1, m); wreg(0, 30'd1); tick(1);
        chk("R10 resume after enable", count, RCV + 1);

        // R3 external clock source, invert, gating
        m = '0; m.clk_src = 2'd1; wreg(1, m); swtrig();
        tick(3);
        chk("R3 internal ignored", count, 0);
        for (int i = 0; i < 3; i++) begin
            xline[0] = 1; step(); xline[0] = 0; step();
        end
        chk("R3 xline0 source", count, 3);
        m.clk_inv = 1; wreg(1, m); swtrig();
        xline[0] = 1; step();
        chk("R3 invert ignores rise", count, 0);
        xline[0] = 0; step();
        chk("R3 invert counts fall", count, 1);
        m = '0; m.gate_sel = 2'd2; wreg(1, m); swtrig();
        tick(2);
        chk("R3 gated low", count, 0);
        xline[1] = 1; step();
        tick(2);
        chk("R3 gated high", count, 2);
        xline[1] = 0; step();

        // R12 / R11 external event as trigger
        m = '0; m.ev_src = 2'd2; m.ev_edge = EDGE_FALL; m.ev_trig = 1;
        wreg(1, m); swtrig();
        tick(4); rd_clear();
        xline[1] = 1; step();
        chk("R12 rise not selected", status[ST_EVT], 0);
        chk("R12 count kept", count, 4);
        xline[1] = 0; step();
        chk("R12 fall event flag", status[ST_EVT], 1);
        chk("R11 event trigger resets", count, 0);
        m.ev_edge = EDGE_NONE; wreg(1, m); rd_clear();
        xline[1] = 1; step(); xline[1] = 0; step();
        chk("R12 edge none", status[ST_EVT], 0);
        m.ev_edge = EDGE_RISE; m.ev_trig = 0; wreg(1, m);
        tick(2);
        xline[1] = 1; step(); xline[1] = 0; step();
        chk("R12 rise flag", status[ST_EVT], 1);
        chk("R11 no trigger without bit", count, 2);

        // R13 read clears flags
        chk("R13 flags before read", status[7:0] != 0, 1);
        rd_clear();
        chk("R13 flags cleared", status[7:0], 0);

        // R14 mask and irq
        m = '0; wreg(1, m); swtrig(); rd_clear();
        wreg(5, 30'h10);
        tick(RCV);
        chk("R14 irq on RC", irq, 1);
        wreg(6, 30'h10);
        chk("R14 irq masked", irq, 0);
        wr_ien = 1; wr_idis = 1; wr_data = 30'h10; step();
        wr_ien = 0; wr_idis = 0; wr_data = '0;
        chk("R14 disable wins", irq, 0);
        wreg(5, 30'h10);
        chk("R14 irq re-enabled", irq, 1);
        rd_clear();
        chk("R14 irq after clear", irq, 0);

        // R2 disable wins over enable
        wreg(0, 30'd3);
        chk("R2 both bits off", status[ST_CLK], 0);
        tick(2);
        chk("R2 frozen while off", count, RCV);
        wreg(0, 30'd1);
        chk("R2 on again", status[ST_CLK], 1);
        wreg(0, 30'd2);
        chk("R2 off", status[ST_CLK], 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule